// File: doc/BRIEF.md
# Stack Machine Branch and PC Unit

This unit owns the program counter of a byte-coded stack machine. Once per executed instruction it looks at the opcode byte, the values the stack logic has already popped for it (a 16-bit address operand and a condition byte), and the two bytes in memory that follow the opcode. From these it works out where execution continues. It also says whether a return address must be pushed, which stack receives it, and whether the current vector has ended.

Two addressing styles coexist. Stack-fed jumps in byte mode move the PC by a signed 8-bit distance. In short mode they load a full 16-bit absolute address. The immediate jumps carry their own 16-bit relative distance in the instruction stream. Every relative distance is measured from the PC after the opcode and any immediate bytes have been fetched. All address arithmetic wraps at 16 bits. Stack storage, memory access and the ALU sit outside this unit.

Top module: `sm_branch_pc`

## Requirements
- R1: During and right after reset, `pc` equals `RESET_PC` (default 16'h0100), and `halt` and `ret_push` are low.
- R2: Opcode bit 7 is keep, bit 6 is return, bit 5 is short and bits 4..0 are the operation. With `step` low the PC holds. Any opcode that is not a control opcode advances the PC by 1.
- R3: JMP (operation 5'h0C) with short clear sets the PC to pc+1 plus the sign-extended `addr_arg[7:0]`, wrapping at 16 bits.
- R4: JMP, JCN and JSR with short set load the PC with `addr_arg`.
- R5: JCN (operation 5'h0D) jumps only when `cond_arg` is nonzero. Otherwise the PC becomes pc+1.
- R6: JSR (operation 5'h0E) raises `ret_push` with `ret_addr` = pc+1. `ret_to_work` equals the return flag (bit 6): high selects the working stack.
- R7: JCI (8'h20) with nonzero `cond_arg` sets the PC to pc+3 + {imm_hi,imm_lo}. With a zero condition the PC becomes pc+3.
- R8: JMI (8'h40) sets the PC to pc+3 + {imm_hi,imm_lo} and pushes nothing. JSI (8'h60) does the same jump and pushes pc+3 to the return stack (`ret_to_work` low).
- R9: LIT is operation 0 with keep set (8'h80, 8'hA0, 8'hC0, 8'hE0). It advances the PC by 2 in byte mode and by 3 in short mode.
- R10: BRK (8'h00) raises `halt` for that step. The PC holds and no push is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction executes this cycle |
| opcode | input | 8 | Current instruction byte |
| addr_arg | input | 16 | Address popped from the stack (low byte used in byte mode) |
| cond_arg | input | 8 | Condition byte popped from the stack |
| imm_hi | input | 8 | Byte at pc+1 |
| imm_lo | input | 8 | Byte at pc+2 |
| pc | output | 16 | Address of the current opcode |
| next_pc | output | 16 | PC that will be loaded if step is high |
| ret_push | output | 1 | Push a return address this step |
| ret_to_work | output | 1 | Return address targets the working stack |
| ret_addr | output | 16 | Return address to push |
| halt | output | 1 | BRK executed this step |

## Verification
The hardest cases to reach are the 16-bit wrap points. A backward signed byte offset has to carry below address zero, and a large immediate distance has to carry past 16'hFFFF. Random walks seldom land the PC close enough to either end. The stimulus therefore uses short-mode JMPs to park the PC just below 16'hFFFF and just above zero, and then issues negative byte jumps and JCI/JMI/JSI with extreme immediates. All of this runs between long random runs that mix control and ordinary opcodes.

// File: rtl/sm_branch_pc.sv
module sm_branch_pc #(
  parameter int          AW       = 16,
  parameter logic [15:0] RESET_PC = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] addr_arg,
  input  logic [7:0]    cond_arg,
  input  logic [7:0]    imm_hi,
  input  logic [7:0]    imm_lo,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_pc,
  output logic          ret_push,
  output logic          ret_to_work,
  output logic [AW-1:0] ret_addr,
  output logic          halt
);
  localparam int EXT = AW - 8;
  localparam logic [4:0] OP_JMP = 5'h0C;
  localparam logic [4:0] OP_JCN = 5'h0D;
  localparam logic [4:0] OP_JSR = 5'h0E;

  logic [4:0] op;
  logic f_keep, f_ret, f_short, op_zero;
  logic [AW-1:0] pc1, pc2, pc3, rel8, imm16, stk_tgt, imm_tgt;

  assign op      = opcode[4:0];
  assign f_keep  = opcode[7];
  assign f_ret   = opcode[6];
  assign f_short = opcode[5];
  assign op_zero = (op == 5'd0);

  assign pc1     = pc + AW'(1);
  assign pc2     = pc + AW'(2);
  assign pc3     = pc + AW'(3);
  assign rel8    = {{EXT{addr_arg[7]}}, addr_arg[7:0]};
  assign imm16   = AW'({imm_hi, imm_lo});
  assign stk_tgt = f_short ? addr_arg : pc1 + rel8;
  assign imm_tgt = pc3 + imm16;

  always_comb begin
    next_pc     = pc1;
    ret_push    = 1'b0;
    ret_to_work = 1'b0;
    ret_addr    = pc1;
    halt        = 1'b0;
    if (step) begin
      if (op_zero && f_keep) begin
        next_pc = f_short ? pc3 : pc2;
      end else if (op_zero) begin
        case ({f_ret, f_short})
          2'b00: begin next_pc = pc; halt = 1'b1; end
          2'b01: next_pc = (cond_arg != 8'd0) ? imm_tgt : pc3;
          2'b10: next_pc = imm_tgt;
          default: begin
            next_pc  = imm_tgt;
            ret_push = 1'b1;
            ret_addr = pc3;
          end
        endcase
      end else if (op == OP_JMP) begin
        next_pc = stk_tgt;
      end else if (op == OP_JCN) begin
        next_pc = (cond_arg != 8'd0) ? stk_tgt : pc1;
      end else if (op == OP_JSR) begin
        next_pc     = stk_tgt;
        ret_push    = 1'b1;
        ret_to_work = f_ret;
      end
    end else begin
      next_pc = pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= next_pc;
  end

  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> pc == RESET_PC);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));

  a_r2_plain_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && opcode[4:0] != 5'd0 && opcode[4:0] != OP_JMP && opcode[4:0] != OP_JCN
     && opcode[4:0] != OP_JSR) |=> pc == $past(pc) + AW'(1));

  a_r4_short_abs: assert property (@(posedge clk) disable iff (!rst_n)
    (step && opcode[5] && (opcode[4:0] == OP_JMP || opcode[4:0] == OP_JSR))
    |=> pc == $past(addr_arg));

  a_r5_jcn_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (step && opcode[4:0] == OP_JCN && cond_arg == 8'd0) |=> pc == $past(pc) + AW'(1));

  a_r6_push_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push |-> step);

  a_r8_jmi_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (step && opcode == 8'h40) |-> !ret_push);

  a_r10_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step && opcode == 8'h00) |=> ($stable(pc) && !$past(ret_push)));

  a_r10_halt_only_brk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (step && opcode == 8'h00));
endmodule

// File: tb/sm_branch_pc_bench.sv
module sm_branch_pc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [15:0] addr_arg = 16'h0;
  logic [7:0] cond_arg = 8'h0, imm_hi = 8'h0, imm_lo = 8'h0;
  logic [15:0] pc, next_pc, ret_addr;
  logic ret_push, ret_to_work, halt;

  int checks = 0;
  int fails = 0;
  logic [15:0] mpc;
  bit done = 0;

  always #2.5 clk = ~clk;

  sm_branch_pc u_sm_branch_pc (
    .clk(clk), .rst_n(rst_n), .step(step), .opcode(opcode), .addr_arg(addr_arg),
    .cond_arg(cond_arg), .imm_hi(imm_hi), .imm_lo(imm_lo), .pc(pc), .next_pc(next_pc),
    .ret_push(ret_push), .ret_to_work(ret_to_work), .ret_addr(ret_addr), .halt(halt));

  function automatic string req_of(input logic [7:0] o);
    if (o == 8'h00) return "R10";
    if (o[4:0] == 5'd0 && o[7]) return "R9";
    if (o == 8'h20) return "R7";
    if (o == 8'h40 || o == 8'h60) return "R8";
    if (o[4:0] == 5'h0E) return "R6";
    if (o[4:0] == 5'h0D) return "R5";
    if (o[4:0] == 5'h0C) return o[5] ? "R4" : "R3";
    return "R2";
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] p, input logic [7:0] o,
      input logic [15:0] a, input logic [7:0] c, input logic [7:0] h, input logic [7:0] l);
    logic [15:0] tgt;
    logic [15:0] imm;
    imm = {h, l};
    tgt = o[5] ? a : p + 16'd1 + {{8{a[7]}}, a[7:0]};
    if (o == 8'h00) return p;
    if (o[4:0] == 5'd0 && o[7]) return o[5] ? p + 16'd3 : p + 16'd2;
    if (o == 8'h20) return (c != 0) ? p + 16'd3 + imm : p + 16'd3;
    if (o == 8'h40 || o == 8'h60) return p + 16'd3 + imm;
    if (o[4:0] == 5'h0C || o[4:0] == 5'h0E) return tgt;
    if (o[4:0] == 5'h0D) return (c != 0) ? tgt : p + 16'd1;
    return p + 16'd1;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic exec(input logic [7:0] o, input logic [15:0] a, input logic [7:0] c,
      input logic [7:0] h, input logic [7:0] l);
    logic [15:0] en;
    string rq;
    rq = req_of(o);
    @(negedge clk);
    step = 1'b1; opcode = o; addr_arg = a; cond_arg = c; imm_hi = h; imm_lo = l;
    #1;
    en = exp_next(mpc, o, a, c, h, l);
    chk(rq, "halt", halt, o == 8'h00);
    if (o[4:0] == 5'h0E) begin
      chk("R6", "push", ret_push, 1);
      chk("R6", "ret_addr", ret_addr, mpc + 16'd1);
      chk("R6", "to_work", ret_to_work, o[6]);
    end else if (o == 8'h60) begin
      chk("R8", "push", ret_push, 1);
      chk("R8", "ret_addr", ret_addr, mpc + 16'd3);
      chk("R8", "to_work", ret_to_work, 0);
    end else begin
      chk(rq, "no push", ret_push, 0);
    end
    @(negedge clk);
    step = 1'b0;
    mpc = en;
    chk(rq, "pc", pc, mpc);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", pc, 16'h0100);
    chk("R1", "reset halt", halt, 0);
    chk("R1", "reset push", ret_push, 0);
    rst_n = 1'b1;
    mpc = 16'h0100;
    @(negedge clk);
    chk("R1", "pc after reset", pc, 16'h0100);
    repeat (3) @(negedge clk);
    chk("R2", "idle hold", pc, 16'h0100);

    exec(8'h18, 0, 0, 0, 0);
    exec(8'h0C, 16'h00FE, 0, 0, 0);
    exec(8'h2C, 16'hFFFE, 0, 0, 0);
    exec(8'h0C, 16'h0010, 0, 0, 0);
    exec(8'h2C, 16'h0002, 0, 0, 0);
    exec(8'h0C, 16'h0080, 0, 0, 0);
    exec(8'h0D, 16'h0005, 8'h00, 0, 0);
    exec(8'h0D, 16'h0005, 8'h01, 0, 0);
    exec(8'h2D, 16'h1234, 8'hFF, 0, 0);
    exec(8'h0E, 16'h0003, 0, 0, 0);
    exec(8'h4E, 16'h0003, 0, 0, 0);
    exec(8'h2E, 16'hFFFD, 0, 0, 0);
    exec(8'h20, 0, 8'h00, 8'h7F, 8'hFF);
    exec(8'h20, 0, 8'h01, 8'hFF, 8'hF0);
    exec(8'h40, 0, 0, 8'h80, 8'h00);
    exec(8'h60, 0, 0, 8'h12, 8'h34);
    exec(8'h80, 0, 0, 0, 0);
    exec(8'hA0, 0, 0, 0, 0);
    exec(8'hC0, 0, 0, 0, 0);
    exec(8'hE0, 0, 0, 0, 0);
    exec(8'h00, 16'hABCD, 8'h01, 8'h11, 8'h22);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] o;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: o = 8'h00;
        1: o = 8'h20;
        2: o = 8'h40;
        3: o = 8'h60;
        4: o = {$urandom_range(4, 7) == 4 ? 3'b100 : 3'($urandom_range(4, 7)), 5'd0};
        5, 6: o = {3'($urandom), 5'($urandom_range(12, 14))};
        default: o = 8'($urandom);
      endcase
      exec(o, 16'($urandom), ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom),
           8'($urandom), 8'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        chk("R2", "idle hold", pc, mpc);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule